// File: doc/BRIEF.md
# Write-Back Cache with Single-Line Flush

This block is a small direct-mapped, write-back data cache. Loads and stores arrive on one command port with a valid/ready handshake. The same port also carries a flush command. Any code can issue a flush; it needs no privilege. A flush names an address. The cache looks up only the one line that holds that address. If that line is resident and modified, the cache first writes it back to memory, then clears it. If the line is resident and unmodified, it is simply dropped. If the line is not resident, the flush does nothing and still reports completion.

Flushes that need no writeback complete one cycle after they are accepted. A new command can be accepted on every cycle. This lets a software loop walk a buffer line by line, for example after writing code into it, without paying for a page-wide or whole-cache purge. The memory side is a line-wide request/acknowledge port. The cache holds that port for line refills and for writebacks. While a memory transaction is outstanding, the command port reports not-ready.

Top module: `flushable_wb_cache`

## Requirements
- R1: After reset, every line is invalid; `req_ready` is 1, and `resp_valid`, `flush_done` and `mem_req` are 0.
- R2: A load that hits returns the addressed word on `resp_rdata` with `resp_valid`, exactly one cycle after acceptance. A store that hits writes the word, marks the line modified and acknowledges one cycle after acceptance. Never assert `resp_valid` and `flush_done` in the same cycle.
- R3: On a load or store miss, the cache reads the line from memory with `mem_we`=0 at the line-aligned address, installs the line, then completes. A store miss merges its word into the refilled line and marks the line modified.
- R4: On a miss whose victim line is modified, first write the victim to memory at its own line address, then refill.
- R5: A flush whose line is resident and modified writes the whole line to memory with `mem_we`=1, then invalidates the line. Its `flush_done` follows the memory acknowledge.
- R6: A flush whose line is resident and unmodified invalidates the line with no memory transaction, and pulses `flush_done` one cycle after acceptance. A later access to that line misses.
- R7: A flush whose line is not resident causes no memory transaction, leaves the cache contents unchanged, and pulses `flush_done` one cycle after acceptance.
- R8: Each accepted flush produces exactly one `flush_done` pulse, in issue order. Flushes that need no writeback are accepted on consecutive cycles.
- R9: While a memory transaction is outstanding, `req_ready` is 0.
- R10: A store to a line that arrives after a flush of that line has been accepted takes effect after the invalidation, as an ordinary miss.
- R11: Command encoding on `req_cmd`: 0 is load, 1 is store, 2 is flush. Address split: bits [3:0] are the byte offset within a 16-byte line, with bits [3:2] selecting the 32-bit word. Bits [9:4] index one of 64 lines. Bits [31:10] form the tag. `mem_addr` is always line-aligned.
- R12: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_addr` and `mem_we` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command accepted when high together with req_valid |
| req_cmd | input | 2 | 0 load, 1 store, 2 flush |
| req_addr | input | 32 | Byte address of the command |
| req_wdata | input | 32 | Store word |
| resp_valid | output | 1 | Load data or store acknowledge, one cycle |
| resp_rdata | output | 32 | Load word (0 for stores) |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for writeback, 0 for refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_ack | input | 1 | Memory accepts write or returns refill data this cycle |
| mem_rdata | input | 128 | Refill line, valid with mem_ack |

## Verification
On every cycle, the assertions check the following:
- no command is accepted while memory is busy;
- a memory request holds its address and direction until it is acknowledged;
- memory addresses are line-aligned;
- a flush pulse comes only from an accepted flush or from a finished writeback;
- an accepted flush never starts a refill.

The bench's reference model covers what needs history, by comparing outcomes on every clock:
- load data after writebacks and refills;
- that an absent-line flush leaves the contents intact;
- that an invalidated line misses afterwards;
- the order of flush completions;
- the cycle counts of single-cycle flushes and of back-to-back flushes;
- a store that follows a dirty flush.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        CMD_LOAD  = 2'd0,
        CMD_STORE = 2'd1,
        CMD_FLUSH = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WRBK = 2'd1,
        ST_FILL = 2'd2
    } state_e;

endpackage

// File: rtl/fwc_tag_store.sv
module fwc_tag_store #(
    parameter int LINES = 64,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] dirty_vec;
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic             v_q;
        logic             m_q;
        logic [TAG_W-1:0] t_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                m_q <= 1'b0;
                t_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                v_q <= wr_valid;
                m_q <= wr_dirty;
                t_q <= wr_tag;
            end
        end

        assign valid_vec[i] = v_q;
        assign dirty_vec[i] = m_q;
        assign tag_arr[i]   = t_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];

endmodule

// File: rtl/fwc_data_store.sv
module fwc_data_store #(
    parameter int LINES  = 64,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_arr [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_arr[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_arr[rd_idx];

endmodule

// File: rtl/flushable_wb_cache.sv
module flushable_wb_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 64,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int WSEL_LO    = $clog2(WORD_BYTES),
    localparam int WSEL_W     = $clog2(LINE_WORDS),
    localparam int OFF_W      = WSEL_LO + WSEL_W,
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W     = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    import fwc_pkg::*;

    typedef struct packed {
        state_e            state;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic              resp_valid;
        logic [WORD_W-1:0] resp_rdata;
        logic              flush_done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_wsel;
    logic              unused_low;

    logic              rd_valid, rd_dirty, hit;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;

    logic              tag_we, tag_wvalid, tag_wdirty;
    logic              data_we;
    logic [LINE_W-1:0] data_wline;

    function automatic logic [WORD_W-1:0] pick_word(logic [LINE_W-1:0] line,
                                                     logic [WSEL_W-1:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_W-1:0] merge_word(logic [LINE_W-1:0] line,
                                                      logic [WSEL_W-1:0] sel,
                                                      logic [WORD_W-1:0] word);
        logic [LINE_W-1:0] res;
        res = line;
        res[sel*WORD_W +: WORD_W] = word;
        return res;
    endfunction

    // Lookup address: the port in idle, the held command otherwise
    assign lk_addr    = (ctrl_q.state == ST_IDLE) ? req_addr : ctrl_q.addr;
    assign lk_idx     = lk_addr[OFF_W +: IDX_W];
    assign lk_tag     = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_wsel    = lk_addr[WSEL_LO +: WSEL_W];
    assign unused_low = ^lk_addr[WSEL_LO-1:0];
    assign hit        = rd_valid && (rd_tag == lk_tag);

    fwc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .wr_en    (tag_we),
        .wr_idx   (lk_idx),
        .wr_valid (tag_wvalid),
        .wr_dirty (tag_wdirty),
        .wr_tag   (lk_tag)
    );

    fwc_data_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_line (rd_line),
        .wr_en   (data_we),
        .wr_idx  (lk_idx),
        .wr_line (data_wline)
    );

    always_comb begin
        ctrl_d            = ctrl_q;
        ctrl_d.resp_valid = 1'b0;
        ctrl_d.flush_done = 1'b0;
        tag_we            = 1'b0;
        tag_wvalid        = 1'b0;
        tag_wdirty        = 1'b0;
        data_we           = 1'b0;
        data_wline        = rd_line;
        mem_req           = 1'b0;
        mem_we            = 1'b0;
        mem_addr          = {lk_tag, lk_idx, {OFF_W{1'b0}}};
        mem_wdata         = rd_line;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.cmd   = cmd_e'(req_cmd);
                    ctrl_d.addr  = req_addr;
                    ctrl_d.wdata = req_wdata;
                    if (cmd_e'(req_cmd) == CMD_FLUSH) begin
                        if (hit && rd_dirty) begin
                            ctrl_d.state = ST_WRBK;
                        end else begin
                            ctrl_d.flush_done = 1'b1;
                            tag_we            = hit;
                        end
                    end else if (hit) begin
                        ctrl_d.resp_valid = 1'b1;
                        if (cmd_e'(req_cmd) == CMD_STORE) begin
                            data_we           = 1'b1;
                            data_wline        = merge_word(rd_line, lk_wsel, req_wdata);
                            tag_we            = 1'b1;
                            tag_wvalid        = 1'b1;
                            tag_wdirty        = 1'b1;
                            ctrl_d.resp_rdata = '0;
                        end else begin
                            ctrl_d.resp_rdata = pick_word(rd_line, lk_wsel);
                        end
                    end else begin
                        ctrl_d.state = (rd_valid && rd_dirty) ? ST_WRBK : ST_FILL;
                    end
                end
            end
            ST_WRBK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {rd_tag, lk_idx, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    if (ctrl_q.cmd == CMD_FLUSH) begin
                        tag_we            = 1'b1;
                        ctrl_d.flush_done = 1'b1;
                        ctrl_d.state      = ST_IDLE;
                    end else begin
                        ctrl_d.state = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    data_we           = 1'b1;
                    tag_we            = 1'b1;
                    tag_wvalid        = 1'b1;
                    ctrl_d.resp_valid = 1'b1;
                    ctrl_d.state      = ST_IDLE;
                    if (ctrl_q.cmd == CMD_STORE) begin
                        data_wline        = merge_word(mem_rdata, lk_wsel, ctrl_q.wdata);
                        tag_wdirty        = 1'b1;
                        ctrl_d.resp_rdata = '0;
                    end else begin
                        data_wline        = mem_rdata;
                        ctrl_d.resp_rdata = pick_word(mem_rdata, lk_wsel);
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready  = (ctrl_q.state == ST_IDLE);
    assign resp_valid = ctrl_q.resp_valid;
    assign resp_rdata = ctrl_q.resp_rdata;
    assign flush_done = ctrl_q.flush_done;

endmodule

// File: rtl/fwc_checks.sv
module fwc_checks #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_cmd,
    input logic              resp_valid,
    input logic              flush_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    // R9: no command accepted while memory is busy
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R12: request held until acknowledged
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: memory traffic is line-aligned
    p_line_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R8: a flush pulse comes from an accepted flush or a finished writeback
    p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> ($past(req_valid && req_ready && (req_cmd == 2'd2)) ||
                        $past(mem_req && mem_ack && mem_we)));

    // R2: completions of the two kinds never overlap
    p_done_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_done && resp_valid));

    // R6: an accepted flush never starts a refill
    p_flush_no_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_cmd == 2'd2)) |=> (!mem_req || mem_we));

endmodule

bind flushable_wb_cache fwc_checks #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cmd    (req_cmd),
    .resp_valid (resp_valid),
    .flush_done (flush_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/flushable_wb_cache_tb_top.sv
module flushable_wb_cache_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_cmd = 2'd0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         flush_done;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #5 clk = ~clk;

    flushable_wb_cache dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .flush_done (flush_done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    string scen = "";

    always @(posedge clk) cyc++;

    typedef struct {
        int          kind;   // 0 load, 1 store, 2 flush
        logic [31:0] data;
        bit          fast;
        int          due;
        string       tag;
    } rsp_t;

    typedef struct {
        bit           we;
        logic [31:0]  addr;
        logic [127:0] data;
        string        tag;
    } mem_t;

    rsp_t rspq[$];
    mem_t memq[$];

    bit           mv [64];
    bit           md [64];
    logic [21:0]  mt [64];
    logic [127:0] mdat [64];
    logic [127:0] mmem [logic [31:0]];

    function automatic logic [127:0] seed_line(logic [31:0] a);
        return {a ^ 32'hC0DE_0000, a + 32'h11, ~a, {a[15:0], a[31:16]}};
    endfunction

    function automatic logic [127:0] get_line(logic [31:0] a);
        if (mmem.exists(a)) return mmem[a];
        return seed_line(a);
    endfunction

    task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Reference model, applied at acceptance
    task automatic model_accept(logic [1:0] cmd, logic [31:0] a, logic [31:0] wd, int due);
        int          idx;
        int          w;
        logic [21:0] tg;
        logic [31:0] la;
        logic [31:0] va;
        bit          hit;
        bit          was_dirty;
        rsp_t        r;
        mem_t        m;
        idx = int'(a[9:4]);
        w   = int'(a[3:2]);
        tg  = a[31:10];
        la  = {a[31:4], 4'b0};
        hit = mv[idx] && (mt[idx] == tg);
        r.due = due;
        if (cmd == 2'd2) begin
            was_dirty = hit && md[idx];
            if (was_dirty) begin
                va = {mt[idx], a[9:4], 4'b0};
                m.we = 1'b1; m.addr = va; m.data = mdat[idx]; m.tag = "R5";
                memq.push_back(m);
                mmem[va] = mdat[idx];
            end
            if (hit) begin
                mv[idx] = 1'b0;
                md[idx] = 1'b0;
            end
            r.kind = 2; r.data = '0; r.fast = !was_dirty;
            r.tag  = (scen != "") ? scen : (was_dirty ? "R5" : (hit ? "R6" : "R7"));
            rspq.push_back(r);
        end else begin
            if (!hit) begin
                if (mv[idx] && md[idx]) begin
                    va = {mt[idx], a[9:4], 4'b0};
                    m.we = 1'b1; m.addr = va; m.data = mdat[idx]; m.tag = "R4";
                    memq.push_back(m);
                    mmem[va] = mdat[idx];
                end
                m.we = 1'b0; m.addr = la; m.data = '0; m.tag = "R3";
                memq.push_back(m);
                mdat[idx] = get_line(la);
                mv[idx] = 1'b1;
                md[idx] = 1'b0;
                mt[idx] = tg;
            end
            r.fast = hit;
            r.tag  = (scen != "") ? scen : (hit ? "R2" : "R3");
            if (cmd == 2'd1) begin
                mdat[idx][w*32 +: 32] = wd;
                md[idx] = 1'b1;
                r.kind = 1; r.data = '0;
            end else begin
                r.kind = 0; r.data = mdat[idx][w*32 +: 32];
            end
            rspq.push_back(r);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_valid || flush_done) begin
                if (rspq.size() == 0) begin
                    check(1'b0, "R8", "unexpected completion", {resp_valid, flush_done}, 0);
                end else begin
                    rsp_t e;
                    e = rspq.pop_front();
                    check((flush_done && e.kind == 2) || (resp_valid && e.kind != 2),
                          e.tag, "completion kind", {resp_valid, flush_done}, e.kind);
                    if (e.kind == 0 && resp_valid)
                        check(resp_rdata == e.data, e.tag, "load data", resp_rdata, e.data);
                    if (e.fast)
                        check(cyc == e.due, e.tag, "completion cycle", cyc, e.due);
                end
            end else if (rspq.size() > 0 && rspq[0].fast && cyc > rspq[0].due) begin
                check(1'b0, rspq[0].tag, "missing completion", cyc, rspq[0].due);
                void'(rspq.pop_front());
            end
            if (mem_req && mem_ack) begin
                check(!req_ready, "R9", "ready during memory transaction", req_ready, 0);
                if (memq.size() == 0) begin
                    check(1'b0, "R7", "unexpected memory transaction", mem_addr, 0);
                end else begin
                    mem_t m;
                    m = memq.pop_front();
                    check(mem_we == m.we && mem_addr == m.addr, m.tag, "memory op/address",
                          {mem_we, mem_addr}, {m.we, m.addr});
                    if (m.we)
                        check(mem_wdata == m.data, m.tag, "writeback line", mem_wdata, m.data);
                end
            end
            if (req_valid && req_ready)
                model_accept(req_cmd, req_addr, req_wdata, cyc + 1);
        end
    end

    // Memory responder: acknowledge on the third cycle of a request
    int          wcnt = 0;
    logic [31:0] first_addr = '0;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt == 0) first_addr = mem_addr;
            wcnt++;
            if (wcnt >= 3) begin
                check(mem_addr == first_addr, "R12", "address held until ack", mem_addr, first_addr);
                mem_ack   = 1'b1;
                mem_rdata = get_line(mem_addr);
            end
        end
    end

    task automatic issue(logic [1:0] cmd, logic [31:0] a, logic [31:0] wd);
        bit acc;
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = a;
        req_wdata = wd;
        forever begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
            #1;
            if (acc) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (rspq.size() != 0 || memq.size() != 0 || mem_req) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        int t0;
        for (int i = 0; i < 64; i++) begin
            mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; mdat[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        check(flush_done == 1'b0, "R1", "flush_done after reset", flush_done, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        @(posedge clk);
        #1;

        // R3 refill then R2 hits on other words of the same line (R11 word select)
        issue(2'd0, 32'h0000_0104, 0);
        scen = "R11";
        issue(2'd0, 32'h0000_0108, 0);
        issue(2'd0, 32'h0000_0100, 0);
        scen = "";
        issue(2'd1, 32'h0000_0104, 32'hDEAD_BEEF);
        issue(2'd0, 32'h0000_0104, 0);
        drain();

        // R3 store miss
        issue(2'd1, 32'h0000_0230, 32'h0BAD_F00D);
        issue(2'd0, 32'h0000_0230, 0);
        drain();

        // R4 dirty victim, same index with a different tag
        scen = "R4";
        issue(2'd0, 32'h0000_0504, 0);
        issue(2'd0, 32'h0000_0104, 0);
        scen = "";
        drain();

        // R5 dirty flush, then the line misses
        issue(2'd1, 32'h0000_010C, 32'hCAFE_0001);
        issue(2'd2, 32'h0000_0108, 0);
        scen = "R5";
        issue(2'd0, 32'h0000_010C, 0);
        scen = "";
        drain();

        // R7 flush of an absent tag at a resident index: no effect
        issue(2'd2, 32'h0000_0904, 0);
        scen = "R7";
        issue(2'd0, 32'h0000_010C, 0);
        scen = "";
        drain();

        // R6 clean flush, then the line misses
        issue(2'd2, 32'h0000_0100, 0);
        scen = "R6";
        issue(2'd0, 32'h0000_010C, 0);
        scen = "";
        drain();

        // R10 store right behind a dirty flush of the same line
        issue(2'd1, 32'h0000_0230, 32'h1111_2222);
        drain();
        scen = "R10";
        issue(2'd2, 32'h0000_0230, 0);
        issue(2'd1, 32'h0000_0234, 32'h1234_5678);
        issue(2'd0, 32'h0000_0234, 0);
        issue(2'd0, 32'h0000_0230, 0);
        scen = "";
        drain();

        // R8 back-to-back flush loop over clean and absent lines
        for (int i = 0; i < 4; i++) issue(2'd0, 32'h0000_1000 + 32'(i * 16), 0);
        drain();
        scen = "R8";
        t0 = cyc;
        for (int i = 0; i < 8; i++) begin
            if (i < 4) issue(2'd2, 32'h0000_1000 + 32'(i * 16), 0);
            else       issue(2'd2, 32'h0000_1060 + 32'(i * 16), 0);
        end
        check(cyc - t0 == 8, "R8", "cycles for 8 back-to-back flushes", cyc - t0, 8);
        drain();

        // R8 mixed loop including modified lines
        issue(2'd1, 32'h0000_1040, 32'hAAAA_0000);
        issue(2'd1, 32'h0000_1054, 32'hBBBB_0000);
        issue(2'd0, 32'h0000_1008, 0);
        for (int i = 0; i < 8; i++) issue(2'd2, 32'h0000_1000 + 32'(i * 16), 0);
        for (int i = 0; i < 8; i++) issue(2'd0, 32'h0000_1000 + 32'(i * 16) + 32'h4, 0);
        scen = "";
        drain();

        // Mixed random traffic over a few conflicting lines
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int          r;
            a = {20'(($urandom % 4)), 2'b00, 4'(($urandom % 4)), 2'(($urandom % 4)), 2'b00};
            a = {a[19:0], 12'b0} >> 12;
            a = {22'(($urandom % 4)), 6'(($urandom % 4)), 2'(($urandom % 4)), 2'b00};
            r = int'($urandom % 8);
            if (r < 3)      issue(2'd0, a, 0);
            else if (r < 6) issue(2'd1, a, $urandom);
            else            issue(2'd2, a, 0);
        end
        drain();

        check(rspq.size() == 0, "R8", "completions outstanding at end", rspq.size(), 0);
        check(memq.size() == 0, "R4", "memory transactions outstanding at end", memq.size(), 0);
        report();
    end

endmodule